// File: doc/BRIEF.md
# Filtered Transaction Statistics Counter

This block keeps one running statistic about the traffic seen at a point in an interconnect. Each cycle it can be shown one transaction, described by a valid flag, a read bit, a write bit, an 8-bit initiator address and an error bit. Each transaction also carries three 12-bit side values: length, pressure and latency. Alongside the transaction the block receives two small counts from an event classifier, one for request hits and one for response hits. It also receives a vector of external event pulses.

Transactions are qualified in two ways. A bank of mask/match filter stages compares each transaction's attributes against stored patterns. A window stage tests whether the chosen side value lies between a programmed lower and upper bound. A 4-bit operation code then decides what is added to the counter in that cycle. The counter saturates instead of wrapping and is cleared by a synchronous clear input. The configuration arrives as plain inputs, and whatever register bank drives them sits outside the block.

Top module: `stat_filter_counter`

## Requirements
- R1: Reset (active-low `rst_n`) forces `count` to 0. A high `clr` sets `count` to 0 at the next clock edge, overriding any operation in that cycle.
- R2: Each filter stage k uses an 11-bit field at bits [k*11 +: 11] of `flt_mask` and `flt_match`. Within that field, bit 10 is read, bit 9 is write, bits 8:1 are the initiator address and bit 0 is error. The attribute word is built the same way. A stage matches when (attribute AND mask) equals (match AND mask), so a mask bit of 0 makes that bit a don't-care.
- R3: A stage hits only when `txn_valid`, `flt_global_en` and its own bit of `flt_stage_en` are all 1 and its pattern matches.
- R4: Operation 0 adds 1 in each cycle in which stage 0 hits.
- R5: Operation 1 adds 1 in each cycle in which `txn_valid` is high and the selected side value v satisfies `thr_min` <= v <= `thr_max`. When `thr_min` > `thr_max` it never adds.
- R6: `info_sel` chooses the side value: 0 selects length, 1 selects pressure, 2 selects latency and 3 selects the constant 0.
- R7: Operation 2 adds the selected side value in each cycle in which stage 0 hits.
- R8: Operation 3 adds 1 when every stage hits. Operation 4 adds 1 when at least one stage hits.
- R9: Operation 5 adds `req_hits`, operation 6 adds `rsp_hits` and operation 7 adds their sum, every cycle.
- R10: Operation 8 adds 1 in each cycle in which `ext_evt[ext_sel]` is high.
- R11: When an addition would exceed the all-ones value, `count` stays at all ones.
- R12: Operation codes 9 to 15 leave `count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous counter clear |
| txn_valid | input | 1 | A transaction is present this cycle |
| txn_rd | input | 1 | Transaction is a read |
| txn_wr | input | 1 | Transaction is a write |
| txn_init | input | 8 | Initiator address |
| txn_err | input | 1 | Transaction ended in error |
| info_len | input | 12 | Length side value |
| info_press | input | 12 | Pressure side value |
| info_lat | input | 12 | Latency side value |
| req_hits | input | 4 | Request hits counted by the classifier this cycle |
| rsp_hits | input | 4 | Response hits counted by the classifier this cycle |
| ext_evt | input | 4 | External event pulses |
| flt_global_en | input | 1 | Enable for all filter stages |
| flt_stage_en | input | 2 | Per-stage filter enable |
| flt_mask | input | 22 | Mask fields, 11 bits per stage |
| flt_match | input | 22 | Match fields, 11 bits per stage |
| thr_min | input | 12 | Lower window bound, inclusive |
| thr_max | input | 12 | Upper window bound, inclusive |
| info_sel | input | 2 | Side value select |
| op_sel | input | 4 | Operation code |
| ext_sel | input | 2 | External event select |
| count | output | 16 | Statistic counter |

## Verification
The assertions assume that the configuration inputs may change in any cycle and that the counts from the classifier are always below 2^4. The monotonic check assumes that only `clr` and reset ever lower the counter. The stimulus changes every input, configuration included, on the falling edge, so each rising edge sees one settled set of values. Masks are drawn sparse and match patterns are derived from the current attributes with few flipped bits, so filter hits and misses both occur often. Window bounds and side values are drawn from the same small range, so empty windows, edge-equal values and values outside the window all appear.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int INIT_W = 8;
  localparam int FLD_W  = INIT_W + 3;

  localparam logic [3:0] OP_FLT0 = 4'd0;
  localparam logic [3:0] OP_WIN  = 4'd1;
  localparam logic [3:0] OP_INFO = 4'd2;
  localparam logic [3:0] OP_ALL  = 4'd3;
  localparam logic [3:0] OP_ANY  = 4'd4;
  localparam logic [3:0] OP_REQ  = 4'd5;
  localparam logic [3:0] OP_RSP  = 4'd6;
  localparam logic [3:0] OP_BOTH = 4'd7;
  localparam logic [3:0] OP_EXT  = 4'd8;

  localparam logic [1:0] SEL_LEN   = 2'd0;
  localparam logic [1:0] SEL_PRESS = 2'd1;
  localparam logic [1:0] SEL_LAT   = 2'd2;

  // Pattern compare: bits with mask 0 are ignored.
  function automatic logic field_match(input logic [FLD_W-1:0] attr,
                                       input logic [FLD_W-1:0] mask,
                                       input logic [FLD_W-1:0] pat);
    return (attr & mask) == (pat & mask);
  endfunction
endpackage

// File: rtl/stat_mask_filter.sv
module stat_mask_filter
  import stat_pkg::*;
#(
  parameter int NUM_FLT = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     valid,
  input  logic                     global_en,
  input  logic [NUM_FLT-1:0]       stage_en,
  input  logic [FLD_W-1:0]         attr,
  input  logic [NUM_FLT*FLD_W-1:0] mask,
  input  logic [NUM_FLT*FLD_W-1:0] pat,
  output logic [NUM_FLT-1:0]       hit,
  output logic                     all_hit,
  output logic                     any_hit
);
  logic gate;
  assign gate = valid & global_en;

  for (genvar k = 0; k < NUM_FLT; k++) begin : g_stage
    logic eq;
    assign eq     = field_match(attr, mask[k*FLD_W +: FLD_W], pat[k*FLD_W +: FLD_W]);
    assign hit[k] = gate & stage_en[k] & eq;
  end

  assign all_hit = &hit;
  assign any_hit = |hit;

  AST_ALL_IMPLIES_ANY: assert property (@(posedge clk) disable iff (!rst_n)
    all_hit |-> any_hit); // R8
  AST_NO_HIT_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!global_en || !valid) |-> (hit == '0)); // R3
endmodule

// File: rtl/stat_window.sv
module stat_window
  import stat_pkg::*;
#(
  parameter int INFO_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [1:0]        info_sel,
  input  logic [INFO_W-1:0] len,
  input  logic [INFO_W-1:0] press,
  input  logic [INFO_W-1:0] lat,
  input  logic [INFO_W-1:0] lo,
  input  logic [INFO_W-1:0] hi,
  output logic [INFO_W-1:0] sel_info,
  output logic              win_hit
);
  always_comb begin
    case (info_sel)
      SEL_LEN:   sel_info = len;
      SEL_PRESS: sel_info = press;
      SEL_LAT:   sel_info = lat;
      default:   sel_info = '0;
    endcase
  end

  logic above_lo, below_hi;
  assign above_lo = (sel_info >= lo);
  assign below_hi = (sel_info <= hi);
  assign win_hit  = valid & above_lo & below_hi;

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (lo > hi) |-> !win_hit); // R5
  AST_ZERO_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (info_sel == 2'd3) |-> (sel_info == '0)); // R6
endmodule

// File: rtl/stat_accum.sv
module stat_accum
  import stat_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int INFO_W  = 12,
  parameter int HIT_W   = 4,
  parameter int NUM_EXT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [3:0]           op_sel,
  input  logic                 flt_hit0,
  input  logic                 all_hit,
  input  logic                 any_hit,
  input  logic                 win_hit,
  input  logic [INFO_W-1:0]    sel_info,
  input  logic [HIT_W-1:0]     req_hits,
  input  logic [HIT_W-1:0]     rsp_hits,
  input  logic [NUM_EXT-1:0]   ext_evt,
  input  logic [(NUM_EXT>1 ? $clog2(NUM_EXT) : 1)-1:0] ext_sel,
  output logic [CNT_W-1:0]     count
);
  localparam int ADD_W = (INFO_W > HIT_W + 1) ? INFO_W : HIT_W + 1;
  localparam int SUM_W = CNT_W + 1;

  logic [ADD_W-1:0] inc;
  logic [SUM_W-1:0] sum;
  logic             ext_hit;
  logic [CNT_W-1:0] count_q;

  always_comb begin
    if (int'(ext_sel) < NUM_EXT) ext_hit = ext_evt[ext_sel];
    else                         ext_hit = 1'b0;
  end

  always_comb begin
    case (op_sel)
      OP_FLT0: inc = ADD_W'(flt_hit0);
      OP_WIN:  inc = ADD_W'(win_hit);
      OP_INFO: inc = flt_hit0 ? ADD_W'(sel_info) : '0;
      OP_ALL:  inc = ADD_W'(all_hit);
      OP_ANY:  inc = ADD_W'(any_hit);
      OP_REQ:  inc = ADD_W'(req_hits);
      OP_RSP:  inc = ADD_W'(rsp_hits);
      OP_BOTH: inc = ADD_W'({1'b0, req_hits} + {1'b0, rsp_hits});
      OP_EXT:  inc = ADD_W'(ext_hit);
      default: inc = '0;
    endcase
  end

  assign sum = {1'b0, count_q} + SUM_W'(inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count_q <= '0;
    else if (clr)         count_q <= '0;
    else if (sum[CNT_W])  count_q <= '1;
    else                  count_q <= sum[CNT_W-1:0];
  end

  assign count = count_q;

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count == '0)); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (count >= $past(count))); // R11
  AST_HOLD_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op_sel > OP_EXT) |=> $stable(count)); // R12
  AST_FLT0_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && op_sel == OP_FLT0 && !flt_hit0) |=> $stable(count)); // R4
endmodule

// File: rtl/stat_filter_counter.sv
module stat_filter_counter
  import stat_pkg::*;
#(
  parameter int NUM_FLT = 2,
  parameter int CNT_W   = 16,
  parameter int INFO_W  = 12,
  parameter int HIT_W   = 4,
  parameter int NUM_EXT = 4,
  localparam int EXT_SEL_W = (NUM_EXT > 1) ? $clog2(NUM_EXT) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     txn_valid,
  input  logic                     txn_rd,
  input  logic                     txn_wr,
  input  logic [INIT_W-1:0]        txn_init,
  input  logic                     txn_err,
  input  logic [INFO_W-1:0]        info_len,
  input  logic [INFO_W-1:0]        info_press,
  input  logic [INFO_W-1:0]        info_lat,
  input  logic [HIT_W-1:0]         req_hits,
  input  logic [HIT_W-1:0]         rsp_hits,
  input  logic [NUM_EXT-1:0]       ext_evt,
  input  logic                     flt_global_en,
  input  logic [NUM_FLT-1:0]       flt_stage_en,
  input  logic [NUM_FLT*FLD_W-1:0] flt_mask,
  input  logic [NUM_FLT*FLD_W-1:0] flt_match,
  input  logic [INFO_W-1:0]        thr_min,
  input  logic [INFO_W-1:0]        thr_max,
  input  logic [1:0]               info_sel,
  input  logic [3:0]               op_sel,
  input  logic [EXT_SEL_W-1:0]     ext_sel,
  output logic [CNT_W-1:0]         count
);
  logic [FLD_W-1:0]   attr;
  logic [NUM_FLT-1:0] flt_hit;
  logic               all_hit, any_hit, win_hit;
  logic [INFO_W-1:0]  sel_info;

  assign attr = {txn_rd, txn_wr, txn_init, txn_err};

  stat_mask_filter #(.NUM_FLT(NUM_FLT)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (txn_valid),
    .global_en (flt_global_en),
    .stage_en  (flt_stage_en),
    .attr      (attr),
    .mask      (flt_mask),
    .pat       (flt_match),
    .hit       (flt_hit),
    .all_hit   (all_hit),
    .any_hit   (any_hit)
  );

  stat_window #(.INFO_W(INFO_W)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid    (txn_valid),
    .info_sel (info_sel),
    .len      (info_len),
    .press    (info_press),
    .lat      (info_lat),
    .lo       (thr_min),
    .hi       (thr_max),
    .sel_info (sel_info),
    .win_hit  (win_hit)
  );

  stat_accum #(
    .CNT_W   (CNT_W),
    .INFO_W  (INFO_W),
    .HIT_W   (HIT_W),
    .NUM_EXT (NUM_EXT)
  ) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .op_sel   (op_sel),
    .flt_hit0 (flt_hit[0]),
    .all_hit  (all_hit),
    .any_hit  (any_hit),
    .win_hit  (win_hit),
    .sel_info (sel_info),
    .req_hits (req_hits),
    .rsp_hits (rsp_hits),
    .ext_evt  (ext_evt),
    .ext_sel  (ext_sel),
    .count    (count)
  );

  AST_STAGE0_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    flt_hit[0] |-> (txn_valid && flt_stage_en[0])); // R3
endmodule

// File: tb/stat_filter_counter_test.sv
module stat_filter_counter_test;
  localparam int NF = 2, FW = 11, CW = 16, IW = 12, HW = 4, NE = 4, ESW = 2;
  localparam longint CMAX = (64'd1 << CW) - 1;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, clr, txn_valid, txn_rd, txn_wr, txn_err;
  logic [7:0] txn_init;
  logic [IW-1:0] info_len, info_press, info_lat, thr_min, thr_max;
  logic [HW-1:0] req_hits, rsp_hits;
  logic [NE-1:0] ext_evt;
  logic flt_global_en;
  logic [NF-1:0] flt_stage_en;
  logic [NF*FW-1:0] flt_mask, flt_match;
  logic [1:0] info_sel;
  logic [3:0] op_sel;
  logic [ESW-1:0] ext_sel;
  logic [CW-1:0] count;

  int checks = 0;
  int fails = 0;
  longint exp_cnt = 0;

  stat_filter_counter uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .txn_valid(txn_valid),
    .txn_rd(txn_rd), .txn_wr(txn_wr), .txn_init(txn_init), .txn_err(txn_err),
    .info_len(info_len), .info_press(info_press), .info_lat(info_lat),
    .req_hits(req_hits), .rsp_hits(rsp_hits), .ext_evt(ext_evt),
    .flt_global_en(flt_global_en), .flt_stage_en(flt_stage_en),
    .flt_mask(flt_mask), .flt_match(flt_match), .thr_min(thr_min),
    .thr_max(thr_max), .info_sel(info_sel), .op_sel(op_sel),
    .ext_sel(ext_sel), .count(count)
  );

  // Bit-by-bit pattern test (R2) with gating (R3).
  function automatic bit stage_ok(int k);
    logic [FW-1:0] a, m, t;
    a = {txn_rd, txn_wr, txn_init, txn_err};
    m = flt_mask[k*FW +: FW];
    t = flt_match[k*FW +: FW];
    if (!(txn_valid && flt_global_en && flt_stage_en[k])) return 1'b0;
    for (int b = 0; b < FW; b++)
      if (m[b] && (a[b] != t[b])) return 1'b0;
    return 1'b1;
  endfunction

  function automatic longint side_value();
    if (info_sel == 2'd0) return longint'(info_len);
    if (info_sel == 2'd1) return longint'(info_press);
    if (info_sel == 2'd2) return longint'(info_lat);
    return 0;
  endfunction

  function automatic longint model_step(longint cur);
    longint add;
    int nhit;
    longint v;
    nhit = 0;
    for (int k = 0; k < NF; k++) nhit += int'(stage_ok(k));
    v = side_value();
    add = 0;
    if (op_sel == 4'd0) add = stage_ok(0) ? 1 : 0;
    else if (op_sel == 4'd1) add = (txn_valid && v >= longint'(thr_min) && v <= longint'(thr_max)) ? 1 : 0;
    else if (op_sel == 4'd2) add = stage_ok(0) ? v : 0;
    else if (op_sel == 4'd3) add = (nhit == NF) ? 1 : 0;
    else if (op_sel == 4'd4) add = (nhit > 0) ? 1 : 0;
    else if (op_sel == 4'd5) add = longint'(req_hits);
    else if (op_sel == 4'd6) add = longint'(rsp_hits);
    else if (op_sel == 4'd7) add = longint'(req_hits) + longint'(rsp_hits);
    else if (op_sel == 4'd8) add = ext_evt[ext_sel] ? 1 : 0;
    if (clr) return 0;
    cur = cur + add;
    if (cur > CMAX) cur = CMAX;
    return cur;
  endfunction

  function automatic string tag_of(logic [3:0] op);
    case (op)
      4'd0: return "R4 (R2 pattern)";
      4'd1: return "R5 (R6 select)";
      4'd2: return "R7 (R6 select)";
      4'd3, 4'd4: return "R8 (R3 gating)";
      4'd5, 4'd6, 4'd7: return "R9";
      4'd8: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string tag, longint e);
    checks++;
    if (count !== CW'(e)) begin
      fails++;
      $display("FAIL %s: count=%0d expected=%0d at %0t", tag, count, e, $time);
    end
  endtask

  task automatic step(string tag);
    exp_cnt = model_step(exp_cnt);
    @(negedge clk);
    check(tag, exp_cnt);
  endtask

  task automatic rnd_inputs(int i);
    logic [FW-1:0] a;
    txn_valid = ($urandom % 8) != 0;
    txn_rd = 1'($urandom); txn_wr = 1'($urandom); txn_err = 1'($urandom);
    txn_init = 8'($urandom);
    a = {txn_rd, txn_wr, txn_init, txn_err};
    for (int k = 0; k < NF; k++) begin
      flt_mask[k*FW +: FW]  = FW'($urandom & $urandom);
      flt_match[k*FW +: FW] = a ^ FW'($urandom & $urandom & $urandom);
    end
    flt_global_en = ($urandom % 4) != 0;
    flt_stage_en = NF'($urandom | $urandom);
    info_len = IW'($urandom % 16); info_press = IW'($urandom % 16);
    info_lat = IW'($urandom % 16);
    thr_min = IW'($urandom % 16); thr_max = IW'($urandom % 16);
    info_sel = 2'($urandom);
    req_hits = HW'($urandom); rsp_hits = HW'($urandom);
    ext_evt = NE'($urandom); ext_sel = ESW'($urandom);
    clr = (i % 61) == 60;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; txn_valid = 1'b0; txn_rd = 1'b0; txn_wr = 1'b0;
    txn_err = 1'b0; txn_init = '0; info_len = '0; info_press = '0; info_lat = '0;
    req_hits = '0; rsp_hits = '0; ext_evt = '0; flt_global_en = 1'b0;
    flt_stage_en = '0; flt_mask = '0; flt_match = '0; thr_min = '0; thr_max = '0;
    info_sel = '0; op_sel = '0; ext_sel = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", 0);
    rst_n = 1'b1;
    step("R1 after reset");

    // Sweep every operation code with varied stimulus.
    for (int op = 0; op < 16; op++) begin
      op_sel = 4'(op);
      for (int i = 0; i < 200; i++) begin
        rnd_inputs(i);
        step(tag_of(op_sel));
      end
    end

    // R2: all-zero mask makes every attribute a match.
    clr = 1'b1; step("R1 clear"); clr = 1'b0;
    op_sel = 4'd0; txn_valid = 1'b1; flt_global_en = 1'b1; flt_stage_en = '1;
    flt_mask = '0; flt_match = '1; txn_rd = 1'b0; txn_wr = 1'b0; txn_init = '0; txn_err = 1'b0;
    step("R2 zero mask");
    check("R2 zero mask count", 1);
    // R2: one masked initiator bit differs -> no hit.
    flt_mask = {NF{11'b000_0000_0010}}; flt_match = {NF{11'b000_0000_0010}};
    step("R2 mismatch");
    check("R2 mismatch count", 1);

    // R3: global enable low blocks any-hit.
    op_sel = 4'd4; flt_mask = '0; flt_global_en = 1'b0;
    step("R3 global off");
    check("R3 global off count", 1);

    // R6: selector 3 adds zero.
    op_sel = 4'd2; flt_global_en = 1'b1; info_sel = 2'd3; info_len = 12'd100;
    step("R6 zero select");
    check("R6 zero select count", 1);

    // R11: saturation with maximum side value.
    info_sel = 2'd0; info_len = 12'hFFF;
    for (int i = 0; i < 20; i++) step("R11 saturate");
    check("R11 at all ones", CMAX);
    op_sel = 4'd7; req_hits = '1; rsp_hits = '1;
    for (int i = 0; i < 3; i++) step("R11 hold at max");

    // R1: clear overrides an active operation.
    clr = 1'b1;
    step("R1 clear priority");
    check("R1 clear priority count", 0);
    clr = 1'b0;
    step("R9 after clear");
    check("R9 after clear count", 30);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule